// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the system clock into time quanta and walks each bus bit through four quantum-sized segments: a one-quantum synchronization segment, a propagation segment, and two phase buffers. At the boundary between the two phase buffers it strobes the receive line as the bit value. At every new bit it raises a start-of-bit strobe that a transmitter can use to launch its next bit. The line uses NRZ coding and carries no clock, so the block aligns its bit grid to falling (recessive-to-dominant) edges of the receive line.

While the bus is idle, a falling edge causes a hard synchronization: the bit restarts at once. After that, a falling edge inside a bit resynchronizes the bit. A late edge stretches the first phase buffer, and an early edge shortens the second, with the correction capped by a jump width. After a run of recessive samples the block returns to idle and waits for the next hard-sync edge. Frame decoding, stuffing, arbitration and error handling belong to the neighbouring logic.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2*(brp_i+1) clock cycles. Every segment boundary, every sample strobe and every start-of-bit strobe falls on this quantum grid, counted from the most recent bit restart.
- R2: Each bit runs through the segments synchronization (code 1, always 1 quantum), propagation (code 2), phase buffer 1 (code 3) and phase buffer 2 (code 4), in that order, on seg_o. Code 0 means idle.
- R3: The segment lengths are derived from the configuration fields as follows. Propagation is prop_i+1, phase buffer 1 is ph1_i+1, phase buffer 2 is ph2_i+1 but never less than 2, and the jump width is sjw_i+1. If the bit total would fall below 8 quanta, the propagation segment is lengthened to bring the total to 8.
- R4: sample_o is high for exactly one clock, in the cycle in which seg_o changes from 3 to 4. sample_bit_o then holds the value rx_i had at that clock edge.
- R5: bit_start_o is high for exactly one clock, in the cycle in which seg_o enters the synchronization segment.
- R6: After reset, seg_o is 0 and both strobes are low. The block stays idle as long as rx_i shows no falling edge.
- R7: In idle, a falling edge on rx_i (1 in the previous clock, 0 now) makes the next cycle show seg_o=1 with bit_start_o high, with the quantum counter restarted.
- R8: A falling edge seen during propagation or phase buffer 1 lengthens phase buffer 1 of that bit by min(e, jump width). Here e is 1 plus the number of whole quanta already spent in the bit after the synchronization segment.
- R9: A falling edge seen during phase buffer 2 sets e to the number of phase buffer 2 quanta left, the current one included. If e exceeds the jump width, phase buffer 2 is shortened by the jump width. Otherwise the bit ends at once and a new synchronization segment starts in the next cycle with the quantum counter restarted.
- R10: At most one resynchronization takes effect per bit. Falling edges during the synchronization segment and all rising edges have no effect on the timing.
- R11: After IDLE_BITS (default 11) consecutive samples of 1, the block returns to idle (seg_o=0) at the end of that bit instead of starting a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| brp_i | input | 6 | Prescaler setting; quantum = 2*(brp_i+1) clocks |
| prop_i | input | 3 | Propagation segment length minus one |
| ph1_i | input | 3 | Phase buffer 1 length minus one |
| ph2_i | input | 3 | Phase buffer 2 length minus one (minimum 2 quanta) |
| sjw_i | input | 2 | Resynchronization jump width minus one |
| rx_i | input | 1 | Synchronized bus receive line, 1 = recessive |
| sample_o | output | 1 | One-clock strobe at the sample point |
| sample_bit_o | output | 1 | Bus value captured at the last sample point |
| bit_start_o | output | 1 | One-clock strobe at the start of each bit |
| seg_o | output | 3 | Current segment code (0 idle, 1 sync, 2 prop, 3 phase 1, 4 phase 2) |

## Verification
The basic sequencing is swept over three prescaler values and 27 segment settings, among them settings that trigger the minimum-length clamp. Every cycle of twelve bits is compared with a segment code, sample strobe and start strobe computed arithmetically. One dominant bit followed by recessive bits tells correct sampling apart from stale values, and it also exercises the return to idle. Directed single-edge patterns place a falling edge at chosen quanta of a bit: early and late in propagation, deep in phase buffer 1 (where the jump-width cap applies), in the synchronization segment, and at two depths of phase buffer 2. Each pattern yields a distinct predicted sample and bit-start cycle. A double-edge pattern tells whether a second correction within one bit is rejected.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int FLD_W   = 3;
    localparam int SJW_W   = 2;
    localparam int LEN_W   = 5;
    localparam int MIN_TQ  = 8;
    localparam int PH2_MIN = 2;

    typedef enum logic [2:0] {
        SEG_IDLE = 3'd0,
        SEG_SYNC = 3'd1,
        SEG_PROP = 3'd2,
        SEG_PH1  = 3'd3,
        SEG_PH2  = 3'd4
    } seg_e;

    typedef struct packed {
        logic [LEN_W-1:0] prop;
        logic [LEN_W-1:0] ph1;
        logic [LEN_W-1:0] ph2;
        logic [LEN_W-1:0] sjw;
    } seg_cfg_t;

    // Turn raw length-minus-one fields into legal quantum counts.
    function automatic seg_cfg_t clamp_cfg(input logic [FLD_W-1:0] p,
                                           input logic [FLD_W-1:0] a,
                                           input logic [FLD_W-1:0] b,
                                           input logic [SJW_W-1:0] j);
        seg_cfg_t c;
        int       floor_v;
        c.ph1 = LEN_W'(a) + LEN_W'(1);
        c.ph2 = LEN_W'(b) + LEN_W'(1);
        if (int'(c.ph2) < PH2_MIN) c.ph2 = LEN_W'(PH2_MIN);
        c.sjw  = LEN_W'(j) + LEN_W'(1);
        c.prop = LEN_W'(p) + LEN_W'(1);
        floor_v = MIN_TQ - 1 - int'(c.ph1) - int'(c.ph2);
        if (int'(c.prop) < floor_v) c.prop = LEN_W'(floor_v);
        return c;
    endfunction

endpackage

// File: rtl/cbt_cfg_clamp.sv
module cbt_cfg_clamp
    import cbt_pkg::*;
(
    input  logic [FLD_W-1:0] prop_f,
    input  logic [FLD_W-1:0] ph1_f,
    input  logic [FLD_W-1:0] ph2_f,
    input  logic [SJW_W-1:0] sjw_f,
    output seg_cfg_t         cfg
);

    always_comb begin
        cfg = clamp_cfg(prop_f, ph1_f, ph2_f, sjw_f);
    end

endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);

    localparam int PC_W = BRP_W + 1;

    logic [PC_W-1:0] pcnt_q;
    logic [PC_W-1:0] last_cnt;

    // Last count of a quantum is 2*(brp+1)-1 = 2*brp+1.
    assign last_cnt = {brp, 1'b1};
    assign tick     = run && !restart && (pcnt_q >= last_cnt);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + PC_W'(1);
        end
    end

    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/cbt_bit_seq.sv
module cbt_bit_seq
    import cbt_pkg::*;
#(
    parameter int IDLE_BITS = 11
) (
    input  logic     clk,
    input  logic     rst,
    input  seg_cfg_t cfg,
    input  logic     rx,
    input  logic     tick,
    output logic     restart,
    output logic     running,
    output seg_e     seg,
    output logic     sample_o,
    output logic     sample_bit_o,
    output logic     bit_start_o
);

    localparam int RC_W = $clog2(IDLE_BITS + 1);

    seg_e             seg_q;
    logic [LEN_W-1:0] q_q;
    logic [LEN_W-1:0] ext_q;
    logic [LEN_W-1:0] shrink_q;
    logic             used_q;
    logic [RC_W-1:0]  rec_q;
    logic             rx_prev_q;
    logic             sample_q;
    logic             sbit_q;
    logic             bstart_q;

    logic             fall;
    logic             hsync;
    logic             late_hit;
    logic             early_hit;
    logic             early_end;
    logic [LEN_W-1:0] e_late;
    logic [LEN_W-1:0] adj_late;
    logic [LEN_W-1:0] e_early;
    logic [LEN_W-1:0] ph1_len;
    logic [LEN_W-1:0] ph2_len;
    logic [LEN_W-1:0] cur_len;
    logic [RC_W-1:0]  rec_inc;

    assign fall      = rx_prev_q && !rx;
    assign running   = (seg_q != SEG_IDLE);
    assign hsync     = !running && fall;
    assign late_hit  = fall && !used_q && ((seg_q == SEG_PROP) || (seg_q == SEG_PH1));
    assign early_hit = fall && !used_q && (seg_q == SEG_PH2);

    // Phase error of a late edge: quanta spent after the sync segment, plus one.
    assign e_late   = ((seg_q == SEG_PROP) ? q_q : (cfg.prop + q_q)) + LEN_W'(1);
    assign adj_late = (e_late > cfg.sjw) ? cfg.sjw : e_late;
    // Phase error of an early edge: quanta of phase 2 still to run.
    assign e_early   = cfg.ph2 - q_q;
    assign early_end = early_hit && (e_early <= cfg.sjw);
    assign restart   = hsync || early_end;

    assign ph1_len = cfg.ph1 + (late_hit ? adj_late : ext_q);
    assign ph2_len = cfg.ph2 - (early_hit ? cfg.sjw : shrink_q);
    assign rec_inc = (rec_q == RC_W'(IDLE_BITS)) ? rec_q : rec_q + RC_W'(1);

    always_comb begin
        case (seg_q)
            SEG_SYNC: cur_len = LEN_W'(1);
            SEG_PROP: cur_len = cfg.prop;
            SEG_PH1:  cur_len = ph1_len;
            SEG_PH2:  cur_len = ph2_len;
            default:  cur_len = LEN_W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q     <= SEG_IDLE;
            q_q       <= '0;
            ext_q     <= '0;
            shrink_q  <= '0;
            used_q    <= 1'b0;
            rec_q     <= '0;
            rx_prev_q <= 1'b1;
            sample_q  <= 1'b0;
            sbit_q    <= 1'b1;
            bstart_q  <= 1'b0;
        end else begin
            rx_prev_q <= rx;
            sample_q  <= 1'b0;
            bstart_q  <= 1'b0;
            if (restart) begin
                seg_q    <= SEG_SYNC;
                q_q      <= '0;
                ext_q    <= '0;
                shrink_q <= '0;
                used_q   <= 1'b0;
                bstart_q <= 1'b1;
                if (hsync) rec_q <= '0;
            end else if (running) begin
                if (late_hit) begin
                    ext_q  <= adj_late;
                    used_q <= 1'b1;
                end
                if (early_hit) begin
                    shrink_q <= cfg.sjw;
                    used_q   <= 1'b1;
                end
                if (tick) begin
                    if (q_q >= cur_len - LEN_W'(1)) begin
                        q_q <= '0;
                        case (seg_q)
                            SEG_SYNC: seg_q <= SEG_PROP;
                            SEG_PROP: seg_q <= SEG_PH1;
                            SEG_PH1: begin
                                seg_q    <= SEG_PH2;
                                sample_q <= 1'b1;
                                sbit_q   <= rx;
                                rec_q    <= rx ? rec_inc : '0;
                            end
                            default: begin
                                ext_q    <= '0;
                                shrink_q <= '0;
                                used_q   <= 1'b0;
                                if (rec_q >= RC_W'(IDLE_BITS)) begin
                                    seg_q <= SEG_IDLE;
                                    rec_q <= '0;
                                end else begin
                                    seg_q    <= SEG_SYNC;
                                    bstart_q <= 1'b1;
                                end
                            end
                        endcase
                    end else begin
                        q_q <= q_q + LEN_W'(1);
                    end
                end
            end
        end
    end

    assign seg          = seg_q;
    assign sample_o     = sample_q;
    assign sample_bit_o = sbit_q;
    assign bit_start_o  = bstart_q;

    assert_sample_width_R4: assert property (@(posedge clk) disable iff (rst)
        sample_q |=> !sample_q);

    assert_sample_point_R4: assert property (@(posedge clk) disable iff (rst)
        sample_q |-> (seg_q == SEG_PH2) && ($past(seg_q) == SEG_PH1));

    assert_start_width_R5: assert property (@(posedge clk) disable iff (rst)
        bstart_q |=> !bstart_q);

    assert_start_in_sync_R5: assert property (@(posedge clk) disable iff (rst)
        bstart_q |-> (seg_q == SEG_SYNC));

    assert_seg_order_R2: assert property (@(posedge clk) disable iff (rst)
        ((seg_q == SEG_PH1) && ($past(seg_q) != SEG_PH1)) |-> ($past(seg_q) == SEG_PROP));

    assert_hard_sync_R7: assert property (@(posedge clk) disable iff (rst)
        ((seg_q == SEG_IDLE) && rx_prev_q && !rx) |=> ((seg_q == SEG_SYNC) && bstart_q));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (seg_q == SEG_IDLE) |-> (!sample_q && !bstart_q));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
#(
    parameter int BRP_W     = 6,
    parameter int IDLE_BITS = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BRP_W-1:0] brp_i,
    input  logic [2:0]       prop_i,
    input  logic [2:0]       ph1_i,
    input  logic [2:0]       ph2_i,
    input  logic [1:0]       sjw_i,
    input  logic             rx_i,
    output logic             sample_o,
    output logic             sample_bit_o,
    output logic             bit_start_o,
    output logic [2:0]       seg_o
);

    seg_cfg_t cfg;
    logic     tick;
    logic     restart;
    logic     running;
    seg_e     seg;

    cbt_cfg_clamp u_clamp (
        .prop_f (prop_i),
        .ph1_f  (ph1_i),
        .ph2_f  (ph2_i),
        .sjw_f  (sjw_i),
        .cfg    (cfg)
    );

    cbt_prescaler #(.BRP_W(BRP_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (restart),
        .brp     (brp_i),
        .tick    (tick)
    );

    cbt_bit_seq #(.IDLE_BITS(IDLE_BITS)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg),
        .rx           (rx_i),
        .tick         (tick),
        .restart      (restart),
        .running      (running),
        .seg          (seg),
        .sample_o     (sample_o),
        .sample_bit_o (sample_bit_o),
        .bit_start_o  (bit_start_o)
    );

    assign seg_o = seg;

endmodule

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] brp_i = '0;
    logic [2:0] prop_i = '0;
    logic [2:0] ph1_i = '0;
    logic [2:0] ph2_i = '0;
    logic [1:0] sjw_i = '0;
    logic       rx_i = 1'b1;
    logic       sample_o;
    logic       sample_bit_o;
    logic       bit_start_o;
    logic [2:0] seg_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int r = 0;
    int n_samp = 0;
    int n_bs = 0;
    int samp_at [16];
    int samp_val [16];
    int bs_at [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    can_bit_timer u0 (
        .clk(clk), .rst(rst), .brp_i(brp_i), .prop_i(prop_i), .ph1_i(ph1_i),
        .ph2_i(ph2_i), .sjw_i(sjw_i), .rx_i(rx_i), .sample_o(sample_o),
        .sample_bit_o(sample_bit_o), .bit_start_o(bit_start_o), .seg_o(seg_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        r++;
        if (sample_o && n_samp < 16) begin
            samp_at[n_samp]  = r;
            samp_val[n_samp] = int'(sample_bit_o);
            n_samp++;
        end
        if (bit_start_o && n_bs < 16) begin
            bs_at[n_bs] = r;
            n_bs++;
        end
    endtask

    task automatic run_to(input int target);
        while (r < target) step();
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        rx_i = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
    endtask

    task automatic hard_sync();
        rx_i   = 1'b0;
        r      = -1;
        n_samp = 0;
        n_bs   = 0;
        for (int i = 0; i < 16; i++) begin
            samp_at[i] = -1; samp_val[i] = -1; bs_at[i] = -1;
        end
        step();
    endtask

    // Resync config: P=2, prop=2, ph1=3, ph2=3, sjw=2 -> 9 quanta, 18 clocks per bit.
    task automatic resync_setup();
        brp_i = 6'd0; prop_i = 3'd1; ph1_i = 3'd2; ph2_i = 3'd2; sjw_i = 2'd1;
        do_reset();
        hard_sync();
        run_to(12);
        rx_i = 1'b1;
    endtask

    initial begin
        int brp_set [3];
        int fld_p [3];
        int fld_a [3];
        int fld_b [3];
        brp_set = '{0, 1, 3};
        fld_p   = '{0, 3, 7};
        fld_a   = '{0, 4, 7};
        fld_b   = '{0, 1, 7};

        // R6: reset state and quiet idle
        do_reset();
        chk("R6 seg after reset", int'(seg_o), 0);
        chk("R6 sample after reset", int'(sample_o), 0);
        chk("R6 bit_start after reset", int'(bit_start_o), 0);
        n_bs = 0; n_samp = 0;
        repeat (40) step();
        chk("R6 still idle", int'(seg_o), 0);
        chk("R6 no strobes while idle", n_bs + n_samp, 0);

        // Sweep: per-cycle arithmetic comparison over 12 bits
        for (int bi = 0; bi < 3; bi++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int ai = 0; ai < 3; ai++) begin
                    for (int ci = 0; ci < 3; ci++) begin
                        int p, pr, a1, b2, tq, sp, blen, lim;
                        p  = 2 * (brp_set[bi] + 1);
                        a1 = fld_a[ai] + 1;
                        b2 = (fld_b[ci] + 1 < 2) ? 2 : fld_b[ci] + 1;
                        pr = fld_p[pi] + 1;
                        if (pr < 7 - a1 - b2) pr = 7 - a1 - b2;
                        tq   = 1 + pr + a1 + b2;
                        sp   = p * (1 + pr + a1);
                        blen = p * tq;
                        lim  = 12 * blen;
                        @(negedge clk);
                        brp_i = 6'(brp_set[bi]); prop_i = 3'(fld_p[pi]);
                        ph1_i = 3'(fld_a[ai]);   ph2_i = 3'(fld_b[ci]);
                        sjw_i = 2'd0;
                        hard_sync();
                        chk("R7 sync after hard edge", int'(seg_o), 1);
                        while (r <= lim + 2) begin
                            int es, eb, ep, o, qi;
                            if (r < lim) begin
                                o  = r % blen;
                                qi = o / p;
                                es = (qi == 0) ? 1 : (qi < 1 + pr) ? 2 : (qi < 1 + pr + a1) ? 3 : 4;
                                eb = (o == 0) ? 1 : 0;
                                ep = (o == sp) ? 1 : 0;
                                chk("R2 segment code", int'(seg_o), es);
                            end else begin
                                eb = 0; ep = 0;
                                chk("R11 idle after recessive run", int'(seg_o), 0);
                            end
                            chk("R4 sample strobe", int'(sample_o), ep);
                            chk("R5 bit_start strobe", int'(bit_start_o), eb);
                            if (ep == 1)
                                chk("R4 sampled value", int'(sample_bit_o), (r < blen) ? 0 : 1);
                            if (r == sp) rx_i = 1'b1;
                            step();
                        end
                        chk("R1 first sample cycle", samp_at[0], sp);
                        chk("R3 bit length in quanta", (bs_at[1] - bs_at[0]) / p, tq);
                        chk("R3 bit length remainder", (bs_at[1] - bs_at[0]) % p, 0);
                    end
                end
            end
        end

        // R8: late edge in propagation, e=2 within jump width
        resync_setup();
        run_to(22); rx_i = 1'b0;
        run_to(60);
        chk("R8 late e=2 sample", samp_at[1], 34);
        chk("R8 late e=2 next bit", bs_at[2], 40);
        chk("R8 late e=2 value", samp_val[1], 0);
        chk("R4 following bit sample", samp_at[2], 52);

        // R8: late edge deep in phase 1, error 4 capped at 2
        resync_setup();
        run_to(26); rx_i = 1'b0;
        run_to(60);
        chk("R8 capped sample", samp_at[1], 34);
        chk("R8 capped next bit", bs_at[2], 40);

        // R8: late edge e=1
        resync_setup();
        run_to(20); rx_i = 1'b0;
        run_to(60);
        chk("R8 late e=1 sample", samp_at[1], 32);
        chk("R8 late e=1 next bit", bs_at[2], 38);

        // R10: second edge in the same bit ignored
        resync_setup();
        run_to(20); rx_i = 1'b0;
        run_to(22); rx_i = 1'b1;
        run_to(26); rx_i = 1'b0;
        run_to(60);
        chk("R10 second edge ignored sample", samp_at[1], 32);
        chk("R10 second edge ignored next bit", bs_at[2], 38);

        // R10: edge during synchronization segment has no effect
        resync_setup();
        run_to(18); rx_i = 1'b0;
        run_to(60);
        chk("R10 sync-seg edge sample", samp_at[1], 30);
        chk("R10 sync-seg edge next bit", bs_at[2], 36);

        // R9: early edge with error 3 > jump width: phase 2 shortened by 2
        resync_setup();
        run_to(30); rx_i = 1'b0;
        run_to(70);
        chk("R9 shortened next bit", bs_at[2], 32);
        chk("R9 shortened following sample", samp_at[2], 44);

        // R9: early edge with error 2 <= jump width: immediate restart
        resync_setup();
        run_to(32); rx_i = 1'b0;
        step();
        chk("R9 immediate restart seg", int'(seg_o), 1);
        chk("R9 immediate restart strobe", int'(bit_start_o), 1);
        run_to(70);
        chk("R9 immediate restart bit", bs_at[2], 33);
        chk("R9 immediate restart sample", samp_at[2], 45);
        chk("R9 immediate restart later bit", bs_at[3], 51);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule